// File: doc/BRIEF.md
# Flash Page Program Sequencer

This block steps the control bits of an on-chip flash array through a timed flow: one page program or one page erase per command. For a program command the host first loads a 128-byte host buffer, then gives a page-aligned start address and the count of real bytes. The sequencer sets write enable and waits. It moves the whole page into the array's data latches, filling every position at or above the count with 0xFF. It then arms a watchdog window, raises the setup bit and then the pulse bit, and clears both, each step held for its own parameterised wait. After that it reads the page back under the verify bit.

Verify builds a reprogram image in which only bits that should be 0 but still read 1 get another pulse. The flow repeats until that image is all 0xFF or until a maximum attempt count is reached. An erase command follows the same timed shape with the erase setup, erase pulse and erase-verify bits. The flash cell is a behavioural model: a program pulse clears, in every byte of the page, the lowest bit that is 1 in the cell and 0 in the latch. An erase pulse sets the whole page to 0xFF.

While an operation runs, outside reads of the array are refused and new commands are ignored. All waits come from one shared down-counter. A second counter of the same kind times the watchdog window.

Top module: `fpg_seq`

## Requirements
- R1: After reset `busy`, `done`, `err_code` and `ctl` are 0 and `rd_ok` is 0 while reset is held. The array reads 0xFF everywhere once idle.
- R2: A command whose `cmd_addr` has any of its low 7 bits set (low byte not 0x00 or 0x80) is rejected. The block ends with `done`=1 and `err_code`=1, raises no control bit and changes no array byte.
- R3: Page positions with index at or above `cmd_len` are written as 0xFF, whatever the host buffer holds there.
- R4: `ctl` bit 6 is write enable, bit 5 program setup, bit 4 erase setup, bit 3 program pulse, bit 2 erase pulse, bit 1 program verify and bit 0 erase verify. Write enable is held at least W_SWE cycles plus the page transfer before any setup bit rises. The program pulse bit rises only while program setup is already high, and it stays high exactly W_PULSE cycles.
- R5: After each verify, only bits that are still 1 where the data asks for 0 receive a further pulse. The command finishes with `err_code`=0 when the page matches. A byte of 0xFC takes 2 pulses and 0xFE takes 1.
- R6: At most MAX_TRY program pulses are given per command. If the page still mismatches after that, `err_code`=2. A byte of 0x00 is then left at 0xF0 when MAX_TRY is 4.
- R7: The watchdog is armed just before a setup bit rises. If WDT_CYC cycles pass before the setup bit is released, all `ctl` bits drop in the next cycle, and `err_code`=3 and `done`=1.
- R8: While `busy` is high, and in the cycle after a command is accepted, `rd_ok` and `rd_data` are 0. When idle, `rd_data` shows the byte at `rd_addr` one cycle later with `rd_ok`=1.
- R9: `cmd_valid` and buffer writes are ignored while `busy` is high.
- R10: An erase command (`cmd_erase`=1) raises erase setup and then the erase pulse, the pulse high exactly W_PULSE cycles. It gives no program pulse and leaves the page reading 0xFF with `err_code`=0.
- R11: At most one of the pulse and verify bits (`ctl` bits 3..0) is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_we | input | 1 | Host buffer write strobe |
| buf_idx | input | 7 | Host buffer byte index |
| buf_data | input | 8 | Host buffer write byte |
| cmd_valid | input | 1 | Start a command (taken only when idle) |
| cmd_erase | input | 1 | 1 = erase page, 0 = program page |
| cmd_addr | input | 9 | Page start address |
| cmd_len | input | 8 | Count of real bytes, 0 to 128 |
| rd_addr | input | 9 | Array read address |
| rd_data | output | 8 | Registered array read byte |
| rd_ok | output | 1 | Read result valid |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last command finished (held until next command) |
| err_code | output | 2 | 0 none, 1 misaligned, 2 verify limit, 3 watchdog |
| ctl | output | 7 | Flash control bits, layout as in R4 |

## Verification
The bench builds two copies of the block. The first uses the default parameters: MAX_TRY of 4, short waits of 2 to 4 cycles, and a watchdog window of 16 cycles, well above the 10-cycle setup-to-release span. With 4 attempts, one-pulse and two-pulse bytes finish cleanly, while a 0x00 byte exhausts the limit and leaves a known partial value. The second copy shrinks the watchdog window to 4 cycles, so it expires in the middle of the program pulse, and the forced release of every control bit can be observed.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  localparam int CTL_W  = 7;
  localparam int CB_SWE = 6;
  localparam int CB_PSU = 5;
  localparam int CB_ESU = 4;
  localparam int CB_P   = 3;
  localparam int CB_E   = 2;
  localparam int CB_PV  = 1;
  localparam int CB_EV  = 0;

  typedef enum logic [3:0] {
    S_IDLE, S_SWE, S_XFER, S_ARM, S_SETUP, S_PULSE,
    S_HOLD, S_REL, S_VSET, S_VERIFY, S_VEND
  } fpg_state_e;

  typedef enum logic [1:0] {
    E_NONE = 2'd0, E_ALIGN = 2'd1, E_VERIFY = 2'd2, E_WDT = 2'd3
  } fpg_err_e;
endpackage

// File: rtl/fpg_timer.sv
module fpg_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> cnt == '0); // R4
endmodule

// File: rtl/fpg_pagebuf.sv
module fpg_pagebuf #(
  parameter int PAGE  = 128,
  parameter int IDX_W = $clog2(PAGE)
) (
  input  logic             clk,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [7:0]       host_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W:0]   rd_len,
  output logic [7:0]       pad_byte,
  input  logic             rp_we,
  input  logic [7:0]       rp_data,
  output logic [7:0]       rp_byte
);
  logic [7:0] host_mem [PAGE];
  logic [7:0] rp_mem   [PAGE];

  always_ff @(posedge clk) begin
    if (host_we) host_mem[host_idx] <= host_data;
  end

  always_ff @(posedge clk) begin
    if (rp_we) rp_mem[rd_idx] <= rp_data;
  end

  assign pad_byte = ({1'b0, rd_idx} < rd_len) ? host_mem[rd_idx] : 8'hFF;
  assign rp_byte  = rp_mem[rd_idx];
endmodule

// File: rtl/fpg_array.sv
module fpg_array #(
  parameter int ARR_BYTES = 512,
  parameter int PAGE      = 128,
  parameter int ADDR_W    = $clog2(ARR_BYTES),
  parameter int IDX_W     = $clog2(PAGE),
  parameter int PG_W      = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PG_W-1:0]   page_sel,
  input  logic              lat_we,
  input  logic [IDX_W-1:0]  lat_idx,
  input  logic [7:0]        lat_data,
  input  logic              pgm_en,
  input  logic              ers_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [7:0] cells [ARR_BYTES];
  logic [7:0] latch [PAGE];
  logic       p_q, e_q;

  function automatic logic [7:0] pulse_cell(input logic [7:0] c, input logic [7:0] l);
    logic [7:0] cand;
    cand = c & ~l;
    return c & ~(cand & (~cand + 8'd1));
  endfunction

  always_ff @(posedge clk) begin
    if (lat_we) latch[lat_idx] <= lat_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q <= 1'b0;
      e_q <= 1'b0;
      for (int k = 0; k < ARR_BYTES; k++) cells[k] <= 8'hFF;
    end else begin
      p_q <= pgm_en;
      e_q <= ers_en;
      if (pgm_en && !p_q) begin
        for (int j = 0; j < PAGE; j++)
          cells[{page_sel, IDX_W'(j)}] <= pulse_cell(cells[{page_sel, IDX_W'(j)}], latch[j]);
      end else if (ers_en && !e_q) begin
        for (int j = 0; j < PAGE; j++)
          cells[{page_sel, IDX_W'(j)}] <= 8'hFF;
      end
    end
  end

  assign rd_data = cells[rd_addr];

  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    !(pgm_en && ers_en)); // R11
endmodule

// File: rtl/fpg_seq.sv
module fpg_seq
  import fpg_pkg::*;
#(
  parameter int ARR_BYTES = 512,
  parameter int PAGE      = 128,
  parameter int MAX_TRY   = 4,
  parameter int TW        = 16,
  parameter int W_SWE     = 3,
  parameter int W_SETUP   = 2,
  parameter int W_PULSE   = 4,
  parameter int W_HOLD    = 2,
  parameter int W_REL     = 2,
  parameter int W_VSET    = 2,
  parameter int W_VEND    = 2,
  parameter int WDT_CYC   = 16,
  localparam int ADDR_W   = $clog2(ARR_BYTES),
  localparam int IDX_W    = $clog2(PAGE),
  localparam int LEN_W    = IDX_W + 1,
  localparam int PG_W     = ADDR_W - IDX_W,
  localparam int TRY_W    = $clog2(MAX_TRY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_we,
  input  logic [IDX_W-1:0]  buf_idx,
  input  logic [7:0]        buf_data,
  input  logic              cmd_valid,
  input  logic              cmd_erase,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_ok,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  output logic [CTL_W-1:0]  ctl
);
  fpg_state_e        state, st_n;
  logic [CTL_W-1:0]  ctl_q, ctl_n;
  logic [IDX_W-1:0]  idx, idx_n;
  logic [PG_W-1:0]   page_q;
  logic [LEN_W-1:0]  len_q;
  logic              is_ers;
  logic [TRY_W-1:0]  tries, tries_n;
  logic              all_ok, ok_n;
  logic              done_q, done_n;
  fpg_err_e          err_q, err_n;
  logic              armed, armed_n;
  logic              accept;
  logic              tld, wld, tzero, wzero, wfire;
  logic [TW-1:0]     tval;
  logic              lat_we, rp_we, host_we;
  logic [7:0]        pad_byte, rp_byte, arr_rd, rp_new, lat_data;
  logic [ADDR_W-1:0] arr_ra;
  logic [7:0]        rd_data_q;
  logic              rd_ok_q;
  logic              idle;

  assign idle    = (state == S_IDLE);
  assign host_we = buf_we && idle;
  assign wfire   = armed && wzero;
  assign rp_new  = pad_byte | ~arr_rd;
  assign lat_data = (tries == '0) ? pad_byte : rp_byte;
  assign arr_ra  = idle ? rd_addr : {page_q, idx};

  fpg_timer #(.TW(TW)) u_wait (
    .clk(clk), .rst(rst), .load(tld), .val(tval), .zero(tzero));

  fpg_timer #(.TW(TW)) u_wdt (
    .clk(clk), .rst(rst), .load(wld), .val(TW'(WDT_CYC - 1)), .zero(wzero));

  fpg_pagebuf #(.PAGE(PAGE)) u_buf (
    .clk(clk), .host_we(host_we), .host_idx(buf_idx), .host_data(buf_data),
    .rd_idx(idx), .rd_len(len_q), .pad_byte(pad_byte),
    .rp_we(rp_we), .rp_data(rp_new), .rp_byte(rp_byte));

  fpg_array #(.ARR_BYTES(ARR_BYTES), .PAGE(PAGE)) u_arr (
    .clk(clk), .rst(rst), .page_sel(page_q),
    .lat_we(lat_we), .lat_idx(idx), .lat_data(lat_data),
    .pgm_en(ctl_q[CB_P]), .ers_en(ctl_q[CB_E]),
    .rd_addr(arr_ra), .rd_data(arr_rd));

  always_comb begin
    st_n    = state;
    ctl_n   = ctl_q;
    idx_n   = idx;
    tries_n = tries;
    ok_n    = all_ok;
    done_n  = done_q;
    err_n   = err_q;
    armed_n = armed;
    accept  = 1'b0;
    tld     = 1'b0;
    tval    = '0;
    wld     = 1'b0;
    lat_we  = 1'b0;
    rp_we   = 1'b0;
    if (wfire) begin
      st_n    = S_IDLE;
      ctl_n   = '0;
      armed_n = 1'b0;
      done_n  = 1'b1;
      err_n   = E_WDT;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          accept  = 1'b1;
          done_n  = 1'b0;
          err_n   = E_NONE;
          tries_n = '0;
          if (cmd_addr[IDX_W-1:0] != '0) begin
            done_n = 1'b1;
            err_n  = E_ALIGN;
          end else begin
            st_n          = S_SWE;
            ctl_n[CB_SWE] = 1'b1;
            tld           = 1'b1;
            tval          = TW'(W_SWE - 1);
          end
        end
        S_SWE: if (tzero) begin
          st_n  = is_ers ? S_ARM : S_XFER;
          idx_n = '0;
        end
        S_XFER: begin
          lat_we = 1'b1;
          idx_n  = idx + 1'b1;
          if (idx == IDX_W'(PAGE - 1)) st_n = S_ARM;
        end
        S_ARM: begin
          wld     = 1'b1;
          armed_n = 1'b1;
          st_n    = S_SETUP;
          ctl_n[is_ers ? CB_ESU : CB_PSU] = 1'b1;
          tld  = 1'b1;
          tval = TW'(W_SETUP - 1);
        end
        S_SETUP: if (tzero) begin
          st_n    = S_PULSE;
          ctl_n[is_ers ? CB_E : CB_P] = 1'b1;
          tries_n = tries + 1'b1;
          tld     = 1'b1;
          tval    = TW'(W_PULSE - 1);
        end
        S_PULSE: if (tzero) begin
          st_n        = S_HOLD;
          ctl_n[CB_P] = 1'b0;
          ctl_n[CB_E] = 1'b0;
          tld         = 1'b1;
          tval        = TW'(W_HOLD - 1);
        end
        S_HOLD: if (tzero) begin
          st_n          = S_REL;
          ctl_n[CB_PSU] = 1'b0;
          ctl_n[CB_ESU] = 1'b0;
          tld           = 1'b1;
          tval          = TW'(W_REL - 1);
        end
        S_REL: if (tzero) begin
          armed_n = 1'b0;
          st_n    = S_VSET;
          ctl_n[is_ers ? CB_EV : CB_PV] = 1'b1;
          tld  = 1'b1;
          tval = TW'(W_VSET - 1);
        end
        S_VSET: if (tzero) begin
          st_n  = S_VERIFY;
          idx_n = '0;
          ok_n  = 1'b1;
        end
        S_VERIFY: begin
          rp_we = !is_ers;
          ok_n  = all_ok && (is_ers ? (arr_rd == 8'hFF) : (rp_new == 8'hFF));
          idx_n = idx + 1'b1;
          if (idx == IDX_W'(PAGE - 1)) begin
            st_n         = S_VEND;
            ctl_n[CB_PV] = 1'b0;
            ctl_n[CB_EV] = 1'b0;
            tld          = 1'b1;
            tval         = TW'(W_VEND - 1);
          end
        end
        S_VEND: if (tzero) begin
          if (all_ok) begin
            st_n   = S_IDLE;
            ctl_n  = '0;
            done_n = 1'b1;
          end else if (tries == TRY_W'(MAX_TRY)) begin
            st_n   = S_IDLE;
            ctl_n  = '0;
            done_n = 1'b1;
            err_n  = E_VERIFY;
          end else begin
            st_n  = is_ers ? S_ARM : S_XFER;
            idx_n = '0;
          end
        end
        default: begin
          st_n  = S_IDLE;
          ctl_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      ctl_q     <= '0;
      idx       <= '0;
      tries     <= '0;
      all_ok    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= E_NONE;
      armed     <= 1'b0;
      page_q    <= '0;
      len_q     <= '0;
      is_ers    <= 1'b0;
      rd_data_q <= '0;
      rd_ok_q   <= 1'b0;
    end else begin
      state  <= st_n;
      ctl_q  <= ctl_n;
      idx    <= idx_n;
      tries  <= tries_n;
      all_ok <= ok_n;
      done_q <= done_n;
      err_q  <= err_n;
      armed  <= armed_n;
      if (accept) begin
        page_q <= cmd_addr[ADDR_W-1:IDX_W];
        len_q  <= cmd_len;
        is_ers <= cmd_erase;
      end
      if (!idle || accept) begin
        rd_data_q <= '0;
        rd_ok_q   <= 1'b0;
      end else begin
        rd_data_q <= arr_rd;
        rd_ok_q   <= 1'b1;
      end
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_ok    = rd_ok_q;
  assign busy     = !idle;
  assign done     = done_q;
  assign err_code = err_q;
  assign ctl      = ctl_q;

  AST_PULSE_NEEDS_SETUP: assert property (@(posedge clk) disable iff (rst)
    ctl_q[CB_P] |-> ctl_q[CB_PSU]); // R4
  AST_SETUP_NEEDS_SWE: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[CB_PSU] || ctl_q[CB_ESU]) |-> ctl_q[CB_SWE]); // R4
  AST_ERASE_NEEDS_SETUP: assert property (@(posedge clk) disable iff (rst)
    ctl_q[CB_E] |-> ctl_q[CB_ESU]); // R10
  AST_ONE_MODE_BIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_q[CB_P], ctl_q[CB_E], ctl_q[CB_PV], ctl_q[CB_EV]})); // R11
  AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_ok_q |-> idle); // R8
  AST_WDT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    wfire |=> (ctl_q == '0 && err_q == E_WDT && done_q)); // R7
  AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (rst)
    tries <= TRY_W'(MAX_TRY)); // R6
  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (rst)
    !idle |=> $stable(page_q) && $stable(is_ers)); // R9
  AST_ALIGN_REJECT: assert property (@(posedge clk) disable iff (rst)
    (idle && cmd_valid && cmd_addr[IDX_W-1:0] != '0) |=>
      (idle && err_q == E_ALIGN && ctl_q == '0)); // R2
endmodule

// File: tb/sim_fpg_seq.sv
module sim_fpg_seq;
  localparam int CLK_NS  = 10;
  localparam int PAGE    = 128;
  localparam int W_SWE   = 3;
  localparam int W_PULSE = 4;
  localparam int LIMIT   = 100000;

  typedef struct packed {
    logic [8:0] addr;
    logic [7:0] len;
    logic [7:0] fill;
    logic [1:0] err;
    logic [2:0] tries;
    logic [7:0] b0;
    logic [7:0] b1;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{9'h000, 8'd128, 8'hFE, 2'd0, 3'd1, 8'hFE, 8'hFE},
    '{9'h080, 8'd1,   8'hFC, 2'd0, 3'd2, 8'hFC, 8'hFF},
    '{9'h100, 8'd128, 8'h00, 2'd2, 3'd4, 8'hF0, 8'hF0},
    '{9'h140, 8'd128, 8'h55, 2'd1, 3'd0, 8'hF0, 8'hF0},
    '{9'h180, 8'd0,   8'h00, 2'd0, 3'd1, 8'hFF, 8'hFF}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       buf_we = 1'b0;
  logic [6:0] buf_idx = '0;
  logic [7:0] buf_data = '0;
  logic       cmd_valid = 1'b0, cmd1_valid = 1'b0;
  logic       cmd_erase = 1'b0;
  logic [8:0] cmd_addr = '0;
  logic [7:0] cmd_len = '0;
  logic [8:0] rd_addr = '0;
  logic [7:0] rd_data, rd_data1;
  logic       rd_ok, rd_ok1, busy, busy1, done, done1;
  logic [1:0] err_code, err_code1;
  logic [6:0] ctl, ctl1;

  int checks = 0, fails = 0, cyc = 0;
  int p_rises = 0, e_rises = 0, p_run = 0, e_run = 0, swe_run = 0;
  int swe_at_psu = -1;
  bit len_bad = 0, order_bad = 0, p1_seen = 0, finished = 0;
  logic [6:0] ctl_prev = '0;

  always #(CLK_NS/2) clk = ~clk;

  fpg_seq u0 (
    .clk(clk), .rst(rst), .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
    .cmd_valid(cmd_valid), .cmd_erase(cmd_erase), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_ok(rd_ok), .busy(busy), .done(done),
    .err_code(err_code), .ctl(ctl));

  fpg_seq #(.WDT_CYC(4)) u1 (
    .clk(clk), .rst(rst), .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
    .cmd_valid(cmd1_valid), .cmd_erase(cmd_erase), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .rd_addr(rd_addr), .rd_data(rd_data1), .rd_ok(rd_ok1), .busy(busy1), .done(done1),
    .err_code(err_code1), .ctl(ctl1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (ctl[3] && !ctl_prev[3]) begin
      p_rises++;
      if (!ctl_prev[5]) order_bad = 1;
    end
    if (ctl[2] && !ctl_prev[2]) e_rises++;
    if (ctl[5] && !ctl_prev[5] && swe_at_psu < 0) swe_at_psu = swe_run;
    if (!ctl[3] && ctl_prev[3]) begin
      if (p_run != W_PULSE) len_bad = 1;
      p_run = 0;
    end else if (ctl[3]) p_run++;
    if (!ctl[2] && ctl_prev[2]) begin
      if (e_run != W_PULSE) len_bad = 1;
      e_run = 0;
    end else if (ctl[2]) e_run++;
    swe_run = ctl[6] ? swe_run + 1 : 0;
    if (ctl1[3]) p1_seen = 1;
    ctl_prev = ctl;
    if (cyc == LIMIT && !finished) begin
      chk(0, "watchdog", cyc, LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic clr_mon();
    p_rises = 0; e_rises = 0; len_bad = 0; order_bad = 0; swe_at_psu = -1;
  endtask

  task automatic fill_buf(input logic [7:0] b);
    for (int i = 0; i < PAGE; i++) begin
      buf_we = 1'b1; buf_idx = 7'(i); buf_data = b;
      @(negedge clk);
    end
    buf_we = 1'b0;
  endtask

  task automatic start_cmd(input bit ers, input logic [8:0] a, input logic [7:0] n);
    clr_mon();
    cmd_erase = ers; cmd_addr = a; cmd_len = n; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [8:0] a, output logic [7:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && err_code == 0, "R1 status", {busy, done, err_code}, 0);
    chk(ctl == 0 && !rd_ok, "R1 ctl/rd_ok", {ctl, rd_ok}, 0);
    rst = 1'b0;
    @(negedge clk);
    rd(9'h000, v);
    chk(rd_ok && v == 8'hFF, "R1 erased read", v, 8'hFF);

    // vector table: R2 R3 R5 R6
    foreach (VEC[k]) begin
      fill_buf(VEC[k].fill);
      start_cmd(1'b0, VEC[k].addr, VEC[k].len);
      wait_idle();
      chk(done && err_code == VEC[k].err, "R2/R5/R6 err_code", err_code, VEC[k].err);
      chk(p_rises == int'(VEC[k].tries), "R5/R6 pulse count", p_rises, VEC[k].tries);
      rd(VEC[k].addr, v);
      chk(v == VEC[k].b0, "R5/R6 byte0", v, VEC[k].b0);
      rd(VEC[k].addr + 9'd1, v);
      chk(v == VEC[k].b1, "R3 byte1 padding", v, VEC[k].b1);
      chk(!len_bad && !order_bad, "R4 pulse width/order", {len_bad, order_bad}, 0);
      if (VEC[k].tries != 0)
        chk(swe_at_psu >= W_SWE + PAGE, "R4 write enable lead", swe_at_psu, W_SWE + PAGE);
      else
        chk(ctl == 0 && swe_at_psu < 0, "R2 no control bits", ctl, 0);
    end

    // R8 and R9: blocked reads, command ignored while busy
    fill_buf(8'hFE);
    start_cmd(1'b0, 9'h000, 8'd128);
    rd_addr = 9'h000;
    repeat (5) @(negedge clk);
    chk(busy && !rd_ok && rd_data == 0, "R8 read blocked", {rd_ok, rd_data}, 0);
    cmd_erase = 1'b1; cmd_valid = 1'b1; buf_we = 1'b1; buf_idx = 7'd0; buf_data = 8'h00;
    @(negedge clk);
    cmd_valid = 1'b0; buf_we = 1'b0;
    wait_idle();
    chk(e_rises == 0 && err_code == 0, "R9 erase ignored", e_rises, 0);
    rd(9'h000, v);
    chk(rd_ok && v == 8'hFE, "R8/R9 read after busy", v, 8'hFE);
    start_cmd(1'b0, 9'h000, 8'd128);
    wait_idle();
    chk(p_rises == 1 && err_code == 0, "R9 buffer write ignored", p_rises, 1);

    // R10: erase
    start_cmd(1'b1, 9'h100, 8'd0);
    wait_idle();
    chk(err_code == 0 && p_rises == 0 && e_rises == 1, "R10 erase flow", {err_code, p_rises, e_rises}, 1);
    chk(!len_bad, "R10 erase pulse width", len_bad, 0);
    rd(9'h100, v);
    chk(v == 8'hFF, "R10 erased byte0", v, 8'hFF);
    rd(9'h17F, v);
    chk(v == 8'hFF, "R10 erased last byte", v, 8'hFF);

    // R7: watchdog expiry in short-window copy
    fill_buf(8'h0F);
    cmd_erase = 1'b0; cmd_addr = 9'h000; cmd_len = 8'd128; cmd1_valid = 1'b1;
    @(negedge clk);
    cmd1_valid = 1'b0;
    while (busy1) @(negedge clk);
    chk(p1_seen, "R7 pulse reached", p1_seen, 1);
    chk(done1 && err_code1 == 2'd3, "R7 watchdog error", err_code1, 3);
    chk(ctl1 == 0, "R7 control bits released", ctl1, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule